// File: doc/BRIEF.md
# Debug Entry Status Tracker

This block holds a processor's debug status: the code of the event that last brought the core into debug, whether the core is halted, and whether a restart out of the halted state has finished. Debug events arrive as one-cycle pulses on a vector. Bit k of that vector carries the event whose cause code is k. An event that is accepted loads its code into a 4-bit cause field.

In halting mode, an accepted event halts the core through a one-cycle halt request. In monitor mode, it raises a one-cycle exception request instead and the core keeps running. While the core is halted, the cause is frozen. A two-flag handshake then tracks the exit. A restart request clears the restarted flag. The core's exit acknowledge clears the halted flag and sets the restarted flag again.

Two read ports show the same status word: one for the core and one for the external debugger. Only the core has a write port, and it reaches the cause field alone. All pins are plain control and status levels or pulses. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `dbg_status_tracker`

## Requirements
- R1: After reset, the cause field reads 0000, the halted flag reads 0, the restarted flag reads 1, and both the halt request and the exception request are low.
- R2: An event accepted in normal state loads its cause code one cycle later. The codes are: 0 halt command from the debug port, 1 hardware breakpoint, 2 watchpoint, 3 software breakpoint instruction, 4 external debug request pin, 5 vector catch. Event input bit k carries code k.
- R3: When several events pulse in the same cycle, the lowest code is loaded.
- R4: In halting mode (monitor_mode_i = 0), an accepted event sets the halted flag one cycle later. In that same cycle, halt_req_o is high for exactly one cycle.
- R5: In monitor mode (monitor_mode_i = 1), an accepted event loads the cause and pulses dbg_exc_o for one cycle. The halted flag stays 0.
- R6: While the halted flag is 1, events do not change the cause field and raise neither the halt request nor the exception request.
- R7: A restart request clears the restarted flag one cycle later, but only when the halted flag is 1 and the restarted flag is 1. In any other state it is ignored.
- R8: The exit acknowledge is honoured only while halted with the restarted flag at 0. It then clears the halted flag and sets the restarted flag, both in the same next cycle. In any other state it is ignored.
- R9: A core write loads core_wr_cause_i into the cause field one cycle later, provided the core is not halted. A write while halted is ignored. If an accepted event arrives in the same cycle as a write, the event's code is loaded.
- R10: Both read ports return the same status word. Bits [3:0] hold the cause, bit 4 holds the halted flag and bit 5 holds the restarted flag. The debugger side has no write path.
- R11: The event logic only ever loads codes below the number of event inputs. The reserved codes 6 to 15 come only from core writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| evt_i | input | 6 | Debug event pulses; bit k carries cause code k |
| monitor_mode_i | input | 1 | 1 selects monitor mode, 0 selects halting mode |
| restart_req_i | input | 1 | Request to leave the halted state |
| core_exited_i | input | 1 | Core acknowledges that it has left the halted state |
| core_wr_en_i | input | 1 | Core write strobe for the cause field |
| core_wr_cause_i | input | 4 | Cause value written by the core |
| core_rd_o | output | 6 | Status word, core view |
| ext_rd_o | output | 6 | Status word, debugger view |
| halt_req_o | output | 1 | One-cycle halt request to the core |
| dbg_exc_o | output | 1 | One-cycle debug exception request (monitor mode) |

## Verification
The assertions assume that the exit acknowledge comes only after a restart request has been taken. They also assume that every event, request and strobe input is a defined level on each clock edge. Inputs arriving outside that order must still be ignored, so the stimulus deliberately sends restart requests and acknowledges in the wrong states. It does this in directed steps and throughout a long random phase. All inputs are driven on the falling edge, so every rising edge samples settled values. In monitor mode the stimulus keeps events sparse, so each exception pulse can be tied to one event.

// File: rtl/dbg_status_pkg.sv
package dbg_status_pkg;
  localparam int unsigned DEF_CAUSE_W = 4;
  localparam int unsigned DEF_NUM_EVT = 6;

  typedef enum logic [DEF_CAUSE_W-1:0] {
    CAUSE_HALT_CMD  = 4'd0,
    CAUSE_HW_BKPT   = 4'd1,
    CAUSE_WATCH     = 4'd2,
    CAUSE_SW_BKPT   = 4'd3,
    CAUSE_EXT_PIN   = 4'd4,
    CAUSE_VEC_CATCH = 4'd5
  } cause_e;

  // status word layout offsets
  localparam int unsigned HALTED_BIT_OFS    = 0;
  localparam int unsigned RESTARTED_BIT_OFS = 1;
endpackage

// File: rtl/dbg_cause_arb.sv
module dbg_cause_arb #(
  parameter int unsigned NUM_EVT = 6,
  parameter int unsigned CODE_W  = 4
) (
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               any_o,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_EVT:0]   seen;
  logic [NUM_EVT-1:0] grant;

  assign seen[0] = 1'b0;

  // ripple priority chain: lowest index wins
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_prio
    assign grant[g]  = evt_i[g] & ~seen[g];
    assign seen[g+1] = seen[g] | evt_i[g];
  end

  assign any_o = seen[NUM_EVT];

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (grant[i]) code_o = code_o | CODE_W'(i);
    end
  end
endmodule

// File: rtl/dbg_cause_reg.sv
module dbg_cause_reg #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [CODE_W-1:0] load_code_i,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_code_i,
  input  logic              wr_block_i,
  output logic [CODE_W-1:0] cause_o
);
  logic [CODE_W-1:0] cause_q;

  // hardware load beats a software write in the same cycle
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cause_q <= '0;
    end else if (load_en_i) begin
      cause_q <= load_code_i;
    end else if (wr_en_i && !wr_block_i) begin
      cause_q <= wr_code_i;
    end
  end

  assign cause_o = cause_q;

  // R9
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_block_i && !load_en_i) |=> (cause_o == $past(wr_code_i)));
endmodule

// File: rtl/dbg_run_ctrl.sv
module dbg_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic monitor_i,
  input  logic restart_req_i,
  input  logic core_exited_i,
  output logic halted_o,
  output logic restarted_o,
  output logic halt_req_o,
  output logic exc_req_o
);
  logic halted_q, restarted_q, hreq_q, exc_q;
  logic take_halt, take_restart, take_exit;

  assign take_halt    = accept_i & ~monitor_i;
  assign take_restart = halted_q & restarted_q & restart_req_i;
  assign take_exit    = halted_q & ~restarted_q & core_exited_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      halted_q    <= 1'b0;
      restarted_q <= 1'b1;
      hreq_q      <= 1'b0;
      exc_q       <= 1'b0;
    end else begin
      hreq_q <= take_halt;
      exc_q  <= accept_i & monitor_i;
      if (take_halt) begin
        halted_q <= 1'b1;
      end else if (take_exit) begin
        halted_q    <= 1'b0;
        restarted_q <= 1'b1;
      end
      if (take_restart) restarted_q <= 1'b0;
    end
  end

  assign halted_o    = halted_q;
  assign restarted_o = restarted_q;
  assign halt_req_o  = hreq_q;
  assign exc_req_o   = exc_q;

  // R4
  halt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_q) |-> hreq_q);
  // R4
  halt_req_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hreq_q |=> !hreq_q);
  // R5
  exc_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_q |-> !halted_q);
  // R7
  restart_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(restarted_q) |-> ($past(halted_q) && $past(restart_req_i)));
  // R8
  exit_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_q && !restarted_q && core_exited_i) |=> (!halted_q && restarted_q));
  // R8
  running_restarted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_q |-> restarted_q);
endmodule

// File: rtl/dbg_status_tracker.sv
module dbg_status_tracker
  import dbg_status_pkg::*;
#(
  parameter int unsigned NUM_EVT = DEF_NUM_EVT,
  parameter int unsigned CAUSE_W = DEF_CAUSE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic                 monitor_mode_i,
  input  logic                 restart_req_i,
  input  logic                 core_exited_i,
  input  logic                 core_wr_en_i,
  input  logic [CAUSE_W-1:0]   core_wr_cause_i,
  output logic [CAUSE_W+1:0]   core_rd_o,
  output logic [CAUSE_W+1:0]   ext_rd_o,
  output logic                 halt_req_o,
  output logic                 dbg_exc_o
);
  localparam int unsigned STATUS_W = CAUSE_W + 2;

  logic               evt_any, accept, halted, restarted;
  logic [CAUSE_W-1:0] evt_code, cause;
  logic [STATUS_W-1:0] status;

  dbg_cause_arb #(.NUM_EVT(NUM_EVT), .CODE_W(CAUSE_W)) arb_i (
    .evt_i  (evt_i),
    .any_o  (evt_any),
    .code_o (evt_code)
  );

  // events only count in normal state
  assign accept = evt_any & ~halted;

  dbg_cause_reg #(.CODE_W(CAUSE_W)) cause_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_en_i   (accept),
    .load_code_i (evt_code),
    .wr_en_i     (core_wr_en_i),
    .wr_code_i   (core_wr_cause_i),
    .wr_block_i  (halted),
    .cause_o     (cause)
  );

  dbg_run_ctrl run_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept),
    .monitor_i     (monitor_mode_i),
    .restart_req_i (restart_req_i),
    .core_exited_i (core_exited_i),
    .halted_o      (halted),
    .restarted_o   (restarted),
    .halt_req_o    (halt_req_o),
    .exc_req_o     (dbg_exc_o)
  );

  assign status[CAUSE_W-1:0]                    = cause;
  assign status[CAUSE_W + HALTED_BIT_OFS]       = halted;
  assign status[CAUSE_W + RESTARTED_BIT_OFS]    = restarted;

  assign core_rd_o = status;
  assign ext_rd_o  = status;

  // R6
  cause_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted && $past(halted)) |-> $stable(cause));
  // R6
  no_req_halted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted && $past(halted)) |-> (!halt_req_o && !dbg_exc_o));
  // R11
  hw_code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (cause < CAUSE_W'(NUM_EVT)));
  // R3
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (evt_i[evt_code] && ((evt_i & ((NUM_EVT'(1) << evt_code) - NUM_EVT'(1))) == '0)));
endmodule

// File: tb/dbg_status_tracker_tb_top.sv
module dbg_status_tracker_tb_top;
  localparam int NE = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [NE-1:0] evt = '0;
  logic       mon = 1'b0, rreq = 1'b0, exited = 1'b0, we = 1'b0;
  logic [3:0] wd = '0;
  logic [5:0] core_rd, ext_rd;
  logic       hreq, exc;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  // reference model state
  int  m_cause = 0;
  bit  m_halted = 0, m_rst = 1, m_hreq = 0, m_exc = 0;

  always #2 clk = ~clk;

  dbg_status_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .monitor_mode_i(mon),
    .restart_req_i(rreq), .core_exited_i(exited), .core_wr_en_i(we),
    .core_wr_cause_i(wd), .core_rd_o(core_rd), .ext_rd_o(ext_rd),
    .halt_req_o(hreq), .dbg_exc_o(exc)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause <= 0; m_halted <= 0; m_rst <= 1; m_hreq <= 0; m_exc <= 0;
    end else begin
      int low;
      low = -1;
      for (int k = NE - 1; k >= 0; k--) if (evt[k]) low = k;
      m_hreq <= 0; m_exc <= 0;
      if (!m_halted && low >= 0) begin
        m_cause <= low;
        if (mon) m_exc <= 1;
        else begin m_halted <= 1; m_hreq <= 1; end
      end else if (we && !m_halted) begin
        m_cause <= int'(wd);
      end
      if (m_halted && m_rst && rreq) m_rst <= 0;
      if (m_halted && !m_rst && exited) begin m_halted <= 0; m_rst <= 1; end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(cur_req, "cause", int'(core_rd[3:0]), m_cause);
      chk(cur_req, "halted", int'(core_rd[4]), int'(m_halted));
      chk(cur_req, "restarted", int'(core_rd[5]), int'(m_rst));
      chk(cur_req, "halt_req", int'(hreq), int'(m_hreq));
      chk(cur_req, "exc_req", int'(exc), int'(m_exc));
      chk("R10", "ext view", int'(ext_rd), int'(core_rd));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_evt(logic [NE-1:0] e);
    evt = e; @(negedge clk); evt = '0;
  endtask

  task automatic leave_halt();
    rreq = 1; @(negedge clk); rreq = 0;
    idle(2);
    exited = 1; @(negedge clk); exited = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // R1 reset word: restarted=1, halted=0, cause=0
    chk("R1", "reset word", int'(core_rd), 32);
    chk("R1", "reset reqs", int'({hreq, exc}), 0);

    // R2 / R4: each event alone in halting mode
    for (int k = 0; k < NE; k++) begin
      cur_req = "R2";
      pulse_evt(NE'(1) << k);
      chk("R2", "code", int'(core_rd[3:0]), k);
      chk("R4", "halted+req", int'({core_rd[4], hreq}), 3);
      cur_req = "R8";
      leave_halt();
      chk("R8", "exit word", int'(core_rd[5:4]), 2);
      idle(1);
    end

    // R3 simultaneous events
    cur_req = "R3";
    pulse_evt(6'b110100);
    chk("R3", "lowest of 2,4,5", int'(core_rd[3:0]), 2);
    leave_halt();
    pulse_evt(6'b111110);
    chk("R3", "lowest of 1..5", int'(core_rd[3:0]), 1);

    // R6 events while halted
    cur_req = "R6";
    pulse_evt(6'b000001);
    chk("R6", "cause frozen", int'(core_rd[3:0]), 1);
    chk("R6", "no reqs", int'({hreq, exc}), 0);
    // R9 write while halted ignored
    cur_req = "R9";
    we = 1; wd = 4'd9; @(negedge clk); we = 0;
    chk("R9", "write while halted", int'(core_rd[3:0]), 1);
    // R8 exit ack before restart ignored
    cur_req = "R8";
    exited = 1; @(negedge clk); exited = 0;
    chk("R8", "early ack ignored", int'(core_rd[5:4]), 3);
    cur_req = "R6";
    rreq = 1; @(negedge clk); rreq = 0;
    pulse_evt(6'b001000);
    chk("R6", "frozen during exit", int'(core_rd[3:0]), 1);
    exited = 1; @(negedge clk); exited = 0;

    // R7 restart in normal state ignored; R8 stray ack ignored
    cur_req = "R7";
    rreq = 1; @(negedge clk); rreq = 0;
    chk("R7", "restart ignored", int'(core_rd[5:4]), 2);
    exited = 1; @(negedge clk); exited = 0;
    chk("R8", "stray ack", int'(core_rd[5:4]), 2);

    // R5 monitor mode
    cur_req = "R5";
    mon = 1;
    pulse_evt(6'b010000);
    chk("R5", "exc pulse, running", int'({exc, core_rd[4]}), 2);
    chk("R5", "cause", int'(core_rd[3:0]), 4);
    pulse_evt(6'b100000);
    chk("R5", "next cause", int'(core_rd[3:0]), 5);
    idle(1);
    chk("R5", "exc dropped", int'(exc), 0);
    mon = 0;

    // R9 core writes
    cur_req = "R9";
    we = 1; wd = 4'd13; @(negedge clk); we = 0;
    chk("R9", "write lands", int'(core_rd[3:0]), 13);
    we = 1; wd = 4'd7; evt = 6'b000100; @(negedge clk); we = 0; evt = '0;
    chk("R9", "event beats write", int'(core_rd[3:0]), 2);
    leave_halt();

    // random phase
    cur_req = "R11";
    for (int c = 0; c < 3000; c++) begin
      evt    = ($urandom % 6 == 0) ? NE'($urandom) : '0;
      if ($urandom % 50 == 0) mon = ~mon;
      rreq   = ($urandom % 5 == 0);
      exited = ($urandom % 4 == 0);
      we     = ($urandom % 4 == 0);
      wd     = 4'($urandom);
      @(negedge clk);
    end
    evt = '0; rreq = 0; exited = 0; we = 0;
    idle(2);
    finish_run();
  end
endmodule